// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a cache and holds lines that are likely to be wanted soon. When the cache misses, it presents the missing line address on the lookup port. The prefetcher compares that address with the oldest entry of its buffer in the same cycle. If they match and the data is present, the line is returned with the lookup and removed from the buffer. Any other lookup is a miss for the prefetcher as well. It then discards its buffer and starts a new stream at the line after the missing one. The cache fetches the missing line itself.

The block keeps DEPTH entries in a circular FIFO. Each entry holds a line tag, a valid flag and a pending flag. The pending flag stays set until memory returns that entry's data. Prefetch requests go out one at a time on a valid/ready request channel, always for the next consecutive line. A slot freed by a hit therefore pulls in one more line. Memory returns data in request order on a response channel. That channel has no ready: at most one response per cycle, and the block always accepts it. Responses to a stream that has been abandoned are counted and dropped. The lookup channel is valid/ready as well. Ready is low only while the head entry matches but its data is still in flight. The cache holds the address until ready rises.

Top module: `sbp_stream_prefetcher`

## Requirements
- R1: A lookup whose address does not match a valid head entry completes in the cycle it is presented (probe_ready high) with probe_hit low. It empties the buffer and starts a new stream at that address plus one.
- R2: After a stream starts at line L, requests go out for L, L+1, L+2, ... in ascending order. Each request is a separate accepted handshake. No request is made while DEPTH entries are held.
- R3: A lookup that matches a head entry whose data has arrived completes in its presented cycle with probe_hit high and probe_data equal to the data memory returned for that line. The entry is removed, so the next entry becomes the head.
- R4: Each removal frees one slot. The next request after it is for the line one above the last line requested.
- R5: Only the head entry is compared. A lookup that matches a later entry but not the head is treated as a miss, as in R1.
- R6: A lookup that matches a head entry whose data is still outstanding is held with probe_ready low. It completes as a hit once the data has arrived.
- R7: Responses to requests issued for an abandoned stream are never stored. The data returned for a line of the current stream is always that line's own response.
- R8: Accepted requests not yet answered, for current and abandoned streams together, never exceed MAX_OUT. mreq_valid stays low while that limit is reached.
- R9: Once mreq_valid is raised, it stays high and mreq_line stays unchanged until mreq_ready is seen high.
- R10: Reset invalidates every entry and cancels the stream: no request is made, and the first lookup after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_valid | input | 1 | Cache presents a missing line address |
| probe_ready | output | 1 | Lookup completes this cycle |
| probe_line | input | LINE_W | Line address of the cache miss |
| probe_hit | output | 1 | Lookup found the line in the buffer (valid with the handshake) |
| probe_data | output | DATA_W | Line data for a hit |
| mreq_valid | output | 1 | Prefetch request to memory |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_line | output | LINE_W | Line address to fetch |
| mrsp_valid | input | 1 | Memory returns data, in request order |
| mrsp_data | input | DATA_W | Returned line data |

## Verification
The bench builds the block with DEPTH 4, MAX_OUT 6, 16-bit line addresses and 32-bit data. With MAX_OUT only two above DEPTH, a stream abandoned while its four requests are outstanding hits the outstanding limit. That makes the request stall and the discard of old responses visible at the ports. Memory latencies of 12 and 30 cycles, with an optional every-third-cycle ready, put the head entry in the pending state when a lookup arrives. The same settings exercise held requests under back-pressure.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  // Circular increment used by every ring pointer in the block.
  function automatic int unsigned sbp_wrap(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sbp_fifo.sv
module sbp_fifo #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [LINE_W-1:0] push_tag,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              pop,
  output logic              head_vld,
  output logic              head_pend,
  output logic [LINE_W-1:0] head_tag,
  output logic [DATA_W-1:0] head_data,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              vld_q  [DEPTH];
  logic              pend_q [DEPTH];
  logic [LINE_W-1:0] tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic [PTR_W-1:0] hd, tl, fp;
  logic [CNT_W-1:0] cnt, npend;

  // Pointers: tail allocates, fill pointer tracks oldest pending, head pops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd <= '0; tl <= '0; fp <= '0; cnt <= '0; npend <= '0;
    end else if (flush) begin
      hd <= '0; tl <= '0; fp <= '0; cnt <= '0; npend <= '0;
    end else begin
      if (push) tl <= PTR_W'(sbp_pkg::sbp_wrap(32'(tl), DEPTH));
      if (fill) fp <= PTR_W'(sbp_pkg::sbp_wrap(32'(fp), DEPTH));
      if (pop)  hd <= PTR_W'(sbp_pkg::sbp_wrap(32'(hd), DEPTH));
      if (push && !pop)      cnt <= cnt + CNT_W'(1);
      else if (pop && !push) cnt <= cnt - CNT_W'(1);
      if (push && !fill)      npend <= npend + CNT_W'(1);
      else if (fill && !push) npend <= npend - CNT_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else if (flush) begin
        vld_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (push && tl == PTR_W'(i)) begin
          vld_q[i]  <= 1'b1;
          pend_q[i] <= 1'b1;
        end
        if (fill && fp == PTR_W'(i)) pend_q[i] <= 1'b0;
        if (pop && hd == PTR_W'(i))  vld_q[i]  <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (push && !flush && tl == PTR_W'(i)) tag_q[i]  <= push_tag;
      if (fill && !flush && fp == PTR_W'(i)) data_q[i] <= fill_data;
    end
  end

  assign head_vld  = vld_q[hd];
  assign head_pend = pend_q[hd];
  assign head_tag  = tag_q[hd];
  assign head_data = data_q[hd];
  assign full      = (cnt == CNT_W'(DEPTH));

  // The generator must never allocate into a full ring.
  assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt < CNT_W'(DEPTH));

  // A response the generator calls live must land on an entry waiting for data.
  assert_fill_matches_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !flush) |-> npend != '0);

endmodule

// File: rtl/sbp_reqgen.sv
module sbp_reqgen #(
  parameter int LINE_W  = 26,
  parameter int MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LINE_W-1:0] flush_line,
  input  logic              slot_free,
  input  logic              mreq_ready,
  input  logic              mrsp_valid,
  output logic              mreq_valid,
  output logic [LINE_W-1:0] mreq_line,
  output logic              load,
  output logic [LINE_W-1:0] load_line,
  output logic              rsp_live
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  logic              active;
  logic [LINE_W-1:0] nxt;
  logic              rq_v, rq_stale;
  logic [LINE_W-1:0] rq_line;
  logic [OUT_W-1:0]  out_live, out_stale, live_d, stale_d;
  logic              fire, rsp_stale;
  logic [OUT_W:0]    out_total;

  assign fire      = rq_v && mreq_ready;
  assign rsp_stale = mrsp_valid && (out_stale != '0);
  assign rsp_live  = mrsp_valid && (out_stale == '0);
  assign out_total = {1'b0, out_live} + {1'b0, out_stale};
  assign load      = active && !flush && !rq_v && slot_free &&
                     (out_total < (OUT_W+1)'(MAX_OUT));
  assign load_line = nxt;
  assign mreq_valid = rq_v;
  assign mreq_line  = rq_line;

  // Outstanding accounting: on a flush every live request turns stale.
  always_comb begin
    live_d  = out_live;
    stale_d = out_stale;
    if (rsp_stale) stale_d = stale_d - OUT_W'(1);
    if (flush) begin
      stale_d = stale_d + out_live - (rsp_live ? OUT_W'(1) : OUT_W'(0));
      live_d  = '0;
      if (fire) stale_d = stale_d + OUT_W'(1);
    end else begin
      if (rsp_live) live_d = live_d - OUT_W'(1);
      if (fire) begin
        if (rq_stale) stale_d = stale_d + OUT_W'(1);
        else          live_d  = live_d + OUT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      nxt       <= '0;
      rq_v      <= 1'b0;
      rq_stale  <= 1'b0;
      rq_line   <= '0;
      out_live  <= '0;
      out_stale <= '0;
    end else begin
      out_live  <= live_d;
      out_stale <= stale_d;
      if (fire) rq_v <= 1'b0;
      if (load) begin
        rq_v     <= 1'b1;
        rq_line  <= nxt;
        rq_stale <= 1'b0;
        nxt      <= nxt + LINE_W'(1);
      end
      if (flush) begin
        active <= 1'b1;
        nxt    <= flush_line + LINE_W'(1);
        if (rq_v && !fire) rq_stale <= 1'b1;
      end
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_line)));

  assert_out_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> out_total < (OUT_W+1)'(MAX_OUT));

endmodule

// File: rtl/sbp_stream_prefetcher.sv
module sbp_stream_prefetcher #(
  parameter int LINE_W  = 26,
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  output logic              probe_ready,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [LINE_W-1:0] mreq_line,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_data
);
  logic              head_vld, head_pend, full;
  logic [LINE_W-1:0] head_tag, load_line;
  logic [DATA_W-1:0] head_data;
  logic              head_match, lk_fire, pop, flush, load, rsp_live;

  // Head-only comparison, done alongside the cache lookup.
  always_comb begin
    head_match  = head_vld && (head_tag == probe_line);
    probe_ready = !(head_match && head_pend);
    probe_hit   = head_match && !head_pend;
    lk_fire     = probe_valid && probe_ready;
    pop         = lk_fire && probe_hit;
    flush       = lk_fire && !probe_hit;
  end
  assign probe_data = head_data;

  sbp_fifo #(.DEPTH(DEPTH), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(load), .push_tag(load_line),
    .fill(rsp_live), .fill_data(mrsp_data),
    .pop(pop),
    .head_vld(head_vld), .head_pend(head_pend), .head_tag(head_tag),
    .head_data(head_data), .full(full)
  );

  sbp_reqgen #(.LINE_W(LINE_W), .MAX_OUT(MAX_OUT)) u_reqgen (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_line(probe_line),
    .slot_free(!full), .mreq_ready(mreq_ready), .mrsp_valid(mrsp_valid),
    .mreq_valid(mreq_valid), .mreq_line(mreq_line),
    .load(load), .load_line(load_line), .rsp_live(rsp_live)
  );

  // A miss leaves an empty ring for the next cycle.
  assert_miss_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_ready && !probe_hit) |=> !head_vld);

  // After a hit the head is the next consecutive line or nothing.
  assert_hit_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_ready && probe_hit) |=>
      (!head_vld || head_tag == $past(head_tag) + LINE_W'(1)));

endmodule

// File: tb/sbp_stream_prefetcher_bench.sv
module sbp_stream_prefetcher_bench;
  localparam int LINE_W  = 16;
  localparam int DATA_W  = 32;
  localparam int DEPTH   = 4;
  localparam int MAX_OUT = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, probe_valid, probe_ready, probe_hit;
  logic [LINE_W-1:0] probe_line, mreq_line;
  logic [DATA_W-1:0] probe_data, mrsp_data;
  logic              mreq_valid, mreq_ready, mrsp_valid;

  sbp_stream_prefetcher #(.LINE_W(LINE_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT))
    u_sbp_stream_prefetcher (
      .clk(clk), .rst_n(rst_n),
      .probe_valid(probe_valid), .probe_ready(probe_ready), .probe_line(probe_line),
      .probe_hit(probe_hit), .probe_data(probe_data),
      .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_line(mreq_line),
      .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [DATA_W-1:0] line_data(input logic [LINE_W-1:0] l);
    return {l ^ 16'hC3A5, l};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Memory model: in-order responses after lat cycles, optional back-pressure.
  int lat = 12;
  bit stall = 0;
  int cyc = 0;
  int stall_ph = 0;
  int outst = 0;
  int max_outst = 0;
  logic [LINE_W-1:0] mq_line[$];
  int                mq_due[$];
  logic [LINE_W-1:0] req_log[$];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq_line.delete();
      mq_due.delete();
      mrsp_valid = 1'b0;
      mrsp_data  = '0;
      mreq_ready = 1'b1;
      outst = 0;
    end else begin
      if (mq_line.size() > 0 && mq_due[0] <= cyc) begin
        mrsp_valid = 1'b1;
        mrsp_data  = line_data(mq_line.pop_front());
        void'(mq_due.pop_front());
        outst--;
      end else begin
        mrsp_valid = 1'b0;
      end
      stall_ph++;
      mreq_ready = stall ? (stall_ph % 3 == 0) : 1'b1;
      if (mreq_valid && mreq_ready) begin
        mq_line.push_back(mreq_line);
        mq_due.push_back(cyc + lat);
        req_log.push_back(mreq_line);
        outst++;
      end
      if (outst > max_outst) max_outst = outst;
    end
  end

  // Scoreboard for lookups.
  typedef struct {
    logic              hit;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;
  exp_t exq[$];

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && probe_valid && probe_ready) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R1", "unexpected lookup completion", 1, 0);
      end else begin
        e = exq.pop_front();
        chk(probe_hit == e.hit, e.req, "hit flag", probe_hit, e.hit);
        if (e.hit) chk(probe_data == e.data, e.req, "hit data", probe_data, e.data);
      end
    end
  end

  task automatic do_probe(input logic [LINE_W-1:0] l, input bit hit,
                          input string req, output int waits);
    exp_t e;
    e.hit  = hit;
    e.data = hit ? line_data(l) : '0;
    e.req  = req;
    exq.push_back(e);
    @(posedge clk); #1;
    probe_valid = 1'b1;
    probe_line  = l;
    waits = 0;
    forever begin
      @(negedge clk);
      if (probe_ready) break;
      waits++;
    end
    @(posedge clk); #1;
    probe_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reqs(input logic [LINE_W-1:0] first, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      if (req_log.size() == 0) begin
        chk(1'b0, req, "missing request", 0, first + i);
        return;
      end
      begin
        logic [LINE_W-1:0] got;
        got = req_log.pop_front();
        chk(got == LINE_W'(first + i), req, "request line", got, first + i);
      end
    end
  endtask

  task automatic expect_log_empty(input string req);
    chk(req_log.size() == 0, req, "extra requests", req_log.size(), 0);
    req_log.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int w;
    rst_n = 1'b0;
    probe_valid = 1'b0;
    probe_line = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mreq_valid == 1'b0, "R10", "request after reset", mreq_valid, 0);

    // R1 / R2: first miss starts a stream of DEPTH lines and then stops.
    do_probe(16'd100, 1'b0, "R1", w);
    settle(40);
    check_reqs(16'd101, DEPTH, "R2");
    expect_log_empty("R2");

    // R3 / R4: head hits, each frees one slot for the next line.
    do_probe(16'd101, 1'b1, "R3", w);
    settle(40);
    check_reqs(16'd105, 1, "R4");
    expect_log_empty("R4");
    do_probe(16'd102, 1'b1, "R3", w);
    settle(40);
    check_reqs(16'd106, 1, "R4");

    // R5: 104 sits behind head 103, so it misses and restarts at 105.
    do_probe(16'd104, 1'b0, "R5", w);
    settle(40);
    check_reqs(16'd105, DEPTH, "R5");
    expect_log_empty("R5");

    // R9: back-pressure on the request channel keeps order.
    stall = 1;
    do_probe(16'd105, 1'b1, "R9", w);
    do_probe(16'd106, 1'b1, "R9", w);
    settle(60);
    check_reqs(16'd109, 2, "R9");
    expect_log_empty("R9");
    stall = 0;

    // R6 / R7 / R8: abandon a stream with all requests in flight.
    lat = 30;
    do_probe(16'd200, 1'b0, "R1", w);
    settle(12);
    do_probe(16'd400, 1'b0, "R7", w);
    settle(10);
    chk(mreq_valid == 1'b0, "R8", "request at outstanding limit", mreq_valid, 0);
    chk(outst == MAX_OUT, "R8", "outstanding at limit", outst, MAX_OUT);
    do_probe(16'd401, 1'b1, "R7", w);
    chk(w > 0, "R6", "cycles held while pending", w, 1);
    settle(80);
    check_reqs(16'd201, DEPTH, "R2");
    check_reqs(16'd401, DEPTH + 1, "R8");
    expect_log_empty("R8");

    // R10: reset mid-stream cancels everything.
    lat = 12;
    do_probe(16'd500, 1'b0, "R1", w);
    settle(40);
    check_reqs(16'd501, DEPTH, "R2");
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle(5);
    chk(mreq_valid == 1'b0, "R10", "request after mid-stream reset", mreq_valid, 0);
    expect_log_empty("R10");
    do_probe(16'd501, 1'b0, "R10", w);
    settle(40);
    check_reqs(16'd502, DEPTH, "R10");
    expect_log_empty("R10");

    chk(max_outst <= MAX_OUT, "R8", "peak outstanding", max_outst, MAX_OUT);
    chk(exq.size() == 0, "R3", "unfinished lookups", exq.size(), 0);

    done = 1;
    report();
    $finish;
  end

endmodule